// File: doc/BRIEF.md
# I2C Master Serial Clock Rate Generator

This block derives the serial clock for an I2C master from the oscillator clock. A 3-bit rate code selects one of seven fixed even divisors of the oscillator (20, 40, 68, 88, 160, 272 or 352 cycles per serial clock period). Code 7 selects a mode in which each single-cycle overflow strobe from an external timer flips the serial clock level. In that mode the bit rate is half the overflow rate.

The clock runs only while master mode is enabled. When master mode is off, or the block is in reset, the internal SCL level rests high and no edge strobes are produced. The outputs are the internal SCL level and two one-cycle strobes that mark its rising and falling transitions. A byte-transfer engine uses these outputs. A change of rate code waits for the next falling SCL transition before it takes effect, so a serial clock period never has a mixed or truncated length.

Top module: `sclRateGen`

## Requirements
- R1: Rate codes 0, 1 and 2 give SCL periods of 20, 40 and 68 oscillator cycles, with high and low phases of exactly half the period each.
- R2: Rate codes 3, 4, 5 and 6 give SCL periods of 88, 160, 272 and 352 cycles, each split evenly between high and low; at an 8 MHz oscillator code 3 yields 90909 Hz (integer part) and code 4 yields exactly 50000 Hz.
- R3: With rate code 7 the SCL level flips once for every cycle in which `tmrTick` is 1, so one full period spans two ticks; without ticks the level holds.
- R4: While `masterEn` is 0, SCL is 1, both strobes are 0, and `tmrTick` has no effect, including a tick in the same cycle that `masterEn` drops; on re-enabling in timer mode the first tick produces a falling transition.
- R5: `sclRise` and `sclFall` are each 1 for exactly one cycle, in the cycle in which `sclOut` takes its new level, and never together.
- R6: A new rate code is adopted only at a falling SCL transition, taking the value present on `rateSel` in that transition's cycle; the high phase in progress and the low and high phases that follow an earlier adoption keep the old length.
- R7: After `masterEn` goes from 0 to 1, the first falling transition occurs exactly divisor/2 cycles after the first clock edge at which enable is seen.
- R8: During and right after reset, `sclOut` is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| rateSel | input | 3 | Rate code: 0..6 fixed divisors, 7 timer-driven |
| masterEn | input | 1 | Master mode enable; 0 holds SCL high |
| tmrTick | input | 1 | One-cycle timer overflow strobe |
| sclOut | output | 1 | Internal SCL level |
| sclRise | output | 1 | One-cycle strobe at the SCL low-to-high transition |
| sclFall | output | 1 | One-cycle strobe at the SCL high-to-low transition |

## Verification
Two functions can coincide. A rate-code change can land in the very cycle of a falling transition, and a timer tick can land in the very cycle that master mode is withdrawn. The bench drives the new code one cycle before a known falling edge and then checks that the low phase that follows already has the new length. It also raises a tick together with the enable drop while SCL is high, and checks that SCL stays high with no falling strobe, and that the next tick after re-enabling produces the fall.

// File: rtl/sclRatePkg.sv
package sclRatePkg;

  localparam int unsigned SEL_W      = 3;
  localparam int unsigned NUM_FIXED  = 7;
  localparam int unsigned TIMER_CODE = 7;

  // Oscillator cycles per serial clock period for each fixed code.
  function automatic int unsigned divFor(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    return 20;
      3'd1:    return 40;
      3'd2:    return 68;
      3'd3:    return 88;
      3'd4:    return 160;
      3'd5:    return 272;
      3'd6:    return 352;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned maxHalf();
    int unsigned m;
    m = 1;
    for (int i = 0; i < int'(NUM_FIXED); i++) begin
      if (divFor(SEL_W'(i)) / 2 > m) m = divFor(SEL_W'(i)) / 2;
    end
    return m;
  endfunction

  localparam int unsigned MAX_HALF = maxHalf();
  localparam int unsigned CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clear;     // idle: counter to zero, SCL high, adopt rate code
    logic advance;   // count one oscillator cycle of the current phase
    logic toggle;    // flip the SCL level this cycle
    logic latchSel;  // adopt the presented rate code
  } sclCtl_t;

endpackage

// File: rtl/sclRateCtl.sv
module sclRateCtl
  import sclRatePkg::*;
(
  input  logic    rst,
  input  logic    masterEn,
  input  logic    tmrTick,
  input  logic    isTimer,
  input  logic    cntDone,
  input  logic    sclLevel,
  output sclCtl_t ctl
);

  logic idle;
  logic flip;

  always_comb begin
    idle = rst || !masterEn;
    if (idle)         flip = 1'b0;
    else if (isTimer) flip = tmrTick;
    else              flip = cntDone;

    ctl.clear    = idle;
    ctl.toggle   = flip;
    ctl.advance  = !idle && !isTimer && !cntDone;
    // A flip while high is a falling transition: the only point of rate change.
    ctl.latchSel = idle || (flip && sclLevel);
  end

endmodule

// File: rtl/sclRateDp.sv
module sclRateDp
  import sclRatePkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  sclCtl_t          ctl,
  input  logic [SEL_W-1:0] rateSel,
  output logic             isTimer,
  output logic             cntDone,
  output logic             sclOut,
  output logic             sclRise,
  output logic             sclFall
);

  logic [SEL_W-1:0] activeSel;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfTerm;

  always_comb begin
    isTimer  = (activeSel == SEL_W'(TIMER_CODE));
    halfTerm = isTimer ? '0 : CNT_W'(divFor(activeSel) / 2 - 1);
    cntDone  = (cnt == halfTerm);
  end

  always_ff @(posedge clk) begin
    if (ctl.latchSel) activeSel <= rateSel;
    if (ctl.clear) begin
      cnt     <= '0;
      sclOut  <= 1'b1;
      sclRise <= 1'b0;
      sclFall <= 1'b0;
    end else begin
      sclRise <= ctl.toggle && !sclOut;
      sclFall <= ctl.toggle && sclOut;
      if (ctl.toggle) begin
        cnt    <= '0;
        sclOut <= !sclOut;
      end else if (ctl.advance) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    ctl.clear |=> (sclOut && !sclRise && !sclFall)); // R4

  AST_RISE_AT_CHANGE: assert property (@(posedge clk) disable iff (rst)
    sclRise |-> (sclOut && !$past(sclOut))); // R5

  AST_FALL_AT_CHANGE: assert property (@(posedge clk) disable iff (rst)
    sclFall |-> (!sclOut && $past(sclOut))); // R5

  AST_CHANGE_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
    ((sclOut != $past(sclOut)) && !$past(ctl.clear)) |-> (sclRise || sclFall)); // R5

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(sclRise && sclFall)); // R5

  AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
    cnt <= halfTerm); // R1

  AST_TIMER_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    isTimer |-> (cnt == '0)); // R3

  AST_SEL_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    (activeSel != $past(activeSel)) |-> ($past(ctl.clear) || sclFall)); // R6

endmodule

// File: rtl/sclRateGen.sv
module sclRateGen
  import sclRatePkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rateSel,
  input  logic             masterEn,
  input  logic             tmrTick,
  output logic             sclOut,
  output logic             sclRise,
  output logic             sclFall
);

  sclCtl_t ctl;
  logic    isTimer;
  logic    cntDone;

  sclRateCtl u_ctl (
    .rst      (rst),
    .masterEn (masterEn),
    .tmrTick  (tmrTick),
    .isTimer  (isTimer),
    .cntDone  (cntDone),
    .sclLevel (sclOut),
    .ctl      (ctl)
  );

  sclRateDp u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .rateSel (rateSel),
    .isTimer (isTimer),
    .cntDone (cntDone),
    .sclOut  (sclOut),
    .sclRise (sclRise),
    .sclFall (sclFall)
  );

endmodule

// File: tb/sclRateGen_tb.sv
module sclRateGen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rateSel = 3'd0;
  logic       masterEn = 1'b0;
  logic       tmrTick = 1'b0;
  logic       sclOut, sclRise, sclFall;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  monOn   = 1'b0;
  logic prevScl = 1'b1;

  always #2 clk = ~clk;

  sclRateGen u_dut (
    .clk(clk), .rst(rst), .rateSel(rateSel), .masterEn(masterEn),
    .tmrTick(tmrTick), .sclOut(sclOut), .sclRise(sclRise), .sclFall(sclFall)
  );

  function automatic int benchDiv(input int code);
    case (code)
      0: return 20;  1: return 40;  2: return 68;  3: return 88;
      4: return 160; 5: return 272; 6: return 352;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R5: strobes must mark exactly the level changes while running.
  always @(negedge clk) begin
    if (monOn) begin
      check(sclRise == (sclOut && !prevScl), "R5 rise strobe", int'(sclRise), int'(sclOut && !prevScl));
      check(sclFall == (!sclOut && prevScl), "R5 fall strobe", int'(sclFall), int'(!sclOut && prevScl));
    end
    prevScl <= sclOut;
  end

  task automatic enableWith(input int code);
    @(posedge clk); #1;
    monOn = 1'b0; masterEn = 1'b0; rateSel = 3'(code);
    repeat (2) @(posedge clk);
    #1; masterEn = 1'b1; monOn = 1'b1;
    @(negedge clk);
  endtask

  task automatic countUntil(input bit wantFall, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(wantFall ? sclFall : sclRise) && n < limit);
  endtask

  task automatic pulseTick();
    tmrTick = 1'b1;
    @(negedge clk);
    tmrTick = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int n, lo, hi, half;
    bit lvl;

    // R8 reset state
    repeat (3) @(posedge clk);
    #1;
    check(sclOut == 1'b1, "R8 scl high in reset", int'(sclOut), 1);
    check(!sclRise && !sclFall, "R8 strobes low in reset", int'(sclRise | sclFall), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(sclOut == 1'b1, "R8 scl high after reset", int'(sclOut), 1);

    // R1/R2/R7 sweep of fixed divisors
    for (int code = 0; code < 7; code++) begin
      half = benchDiv(code) / 2;
      enableWith(code);
      countUntil(1'b1, 1000, n);
      check(n == half, "R7 first high phase", n, half);
      for (int p = 0; p < 2; p++) begin
        countUntil(1'b0, 1000, lo);
        countUntil(1'b1, 1000, hi);
        check(lo == half, code < 3 ? "R1 low phase" : "R2 low phase", lo, half);
        check(hi == half, code < 3 ? "R1 high phase" : "R2 high phase", hi, half);
        check(lo + hi == benchDiv(code), code < 3 ? "R1 period" : "R2 period", lo + hi, benchDiv(code));
        if (code == 3) check(8000000 / (lo + hi) == 90909, "R2 rate 90.91k", 8000000 / (lo + hi), 90909);
        if (code == 4) check(8000000 / (lo + hi) == 50000 && 8000000 % (lo + hi) == 0,
                             "R2 rate 50k", 8000000 / (lo + hi), 50000);
      end
    end

    // R4: disable mid-low in fixed mode
    enableWith(0);
    countUntil(1'b1, 100, n);
    @(posedge clk); #1; monOn = 1'b0; masterEn = 1'b0;
    repeat (2) @(negedge clk);
    check(sclOut == 1'b1, "R4 high when disabled", int'(sclOut), 1);

    // R6: change during high phase waits for the fall
    enableWith(4);
    countUntil(1'b1, 30, n);
    rateSel = 3'd0;
    countUntil(1'b1, 1000, n);
    check(n == 50, "R6 high phase keeps old length", n, 50);
    countUntil(1'b0, 1000, lo);
    countUntil(1'b1, 1000, hi);
    check(lo == 10 && hi == 10, "R6 new code after fall", lo + hi, 20);

    // R6: change just after a fall applies only at the next fall
    rateSel = 3'd1;
    countUntil(1'b0, 1000, lo);
    countUntil(1'b1, 1000, hi);
    check(lo + hi == 20, "R6 old period kept", lo + hi, 20);
    countUntil(1'b0, 1000, lo);
    countUntil(1'b1, 1000, hi);
    check(lo == 20 && hi == 20, "R6 later period uses new code", lo + hi, 40);

    // R6 coincidence: code change in the cycle of the falling transition
    countUntil(1'b0, 1000, lo);
    countUntil(1'b1, 19, n);
    rateSel = 3'd2;
    countUntil(1'b1, 1000, n);
    check(n == 1, "R6 fall timing unchanged", n, 1);
    countUntil(1'b0, 1000, lo);
    check(lo == 34, "R6 code taken at fall cycle", lo, 34);

    // R6/R3: switch to timer mode; SCL stays low without ticks
    rateSel = 3'd7;
    countUntil(1'b1, 1000, n);
    check(n == 34, "R6 fall before timer mode", n, 34);
    repeat (30) @(negedge clk);
    check(sclOut == 1'b0, "R3 level holds without ticks", int'(sclOut), 0);
    pulseTick();
    check(sclOut == 1'b1 && sclRise, "R3 tick raises SCL", int'(sclOut), 1);

    // R3 timer sweep with varied gaps
    enableWith(7);
    lvl = 1'b1;
    for (int g = 0; g < 6; g++) begin
      pulseTick();
      lvl = !lvl;
      check(sclOut == lvl, "R3 tick flips level", int'(sclOut), int'(lvl));
      for (int w = 0; w < (g * 3) % 7; w++) begin
        @(negedge clk);
        check(sclOut == lvl, "R3 level stable between ticks", int'(sclOut), int'(lvl));
      end
    end

    // R4: ticks while disabled are ignored
    @(posedge clk); #1; monOn = 1'b0; masterEn = 1'b0;
    @(negedge clk);
    for (int t = 0; t < 4; t++) begin
      pulseTick();
      check(sclOut == 1'b1 && !sclRise && !sclFall, "R4 tick ignored when off", int'(sclOut), 1);
    end

    // R4 coincidence: tick in the same cycle enable drops, SCL high
    enableWith(7);
    pulseTick();
    pulseTick();
    check(sclOut == 1'b1, "R3 two ticks return high", int'(sclOut), 1);
    @(posedge clk); #1; monOn = 1'b0; masterEn = 1'b0; tmrTick = 1'b1;
    @(negedge clk);
    tmrTick = 1'b0;
    check(sclOut == 1'b1 && !sclFall, "R4 tick with disable ignored", int'(sclOut), 1);
    enableWith(7);
    pulseTick();
    check(sclOut == 1'b0 && sclFall, "R4 first tick after enable falls", int'(sclOut), 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule